// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block runs single read and write transfers to memory or I/O space over a bus whose low data byte shares its wires with the low byte of the address. A client presents a 20-bit address, a space select (memory or I/O), a direction and one byte of write data. The controller then steps through a fixed sequence of clock states. T1 places the address and raises the latch strobe. T2 and T3 assert the read or write strobe together with the data enable. T4 drops every strobe and reports completion. Slow devices stretch a transfer by holding the ready input low, and each low sample adds one wait state between T2 and T3.

An address latch inside the block captures the full address while the strobe is high. It holds that address for the rest of the transfer, so a device sees a steady address while the shared byte lines carry data. A wait-state ceiling stops a device that never answers from hanging the client: once the ceiling is reached, the transfer closes with an error flag. A new request can start straight from T4 with no idle cycle in between.

Top module: `mux_bus_ctrl`

## Requirements
- R1: With `bus_ready` high at the end of T2, a transfer lasts exactly four clocks: `addr_strobe` is high in the first clock and `done` is high in the fourth.
- R2: In T1 `addr_strobe` is high for exactly one clock, `ad_oe` is 1, `ad_out` carries address bits 7..0 and `addr_hi` carries address bits 19..8. `xmit` is 1 for a write and 0 for a read, and `io_sel` is 1 for I/O space and 0 for memory. Both hold their values from T1 through T4.
- R3: From T2 until the clock before T4, `data_en` is 1. `rd_en` is 1 for a read and `wr_en` is 1 for a write. For a write `ad_oe` is 1 and `ad_out` equals the write data. For a read `ad_oe` is 0.
- R4: `bus_ready` is sampled at the end of T2 and at the end of every wait state. Each low sample adds one wait-state clock before T3, so with n wait states `done` comes in clock 4+n.
- R5: In a read, `ad_in` is captured at the end of T3. The captured byte is on `rdata` while `done` is high, and it stays there until the next read.
- R6: In T4 `rd_en`, `wr_en` and `data_en` are 0. `done` is high for exactly one clock.
- R7: From the clock after T1 through T4, `latched_addr` equals the requested address and does not change.
- R8: In a write, `ad_oe` stays 1 and `ad_out` keeps the write data during T4, after `wr_en` has fallen.
- R9: If `bus_ready` is still low at the end of the MAX_WAIT-th wait state, the transfer goes straight to T4 without T3. `err` is high together with `done`, and the transfer lasts MAX_WAIT+3 clocks. `err` is 0 in every transfer that completes normally.
- R10: `req_ready` is 1 only in idle and in T4. A request that is held during T4 starts its T1 in the very next clock.
- R11: After reset `addr_strobe`, `rd_en`, `wr_en`, `data_en`, `ad_oe`, `done` and `err` are 0, and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 20 | Transfer address |
| req_io | input | 1 | 1 selects I/O space, 0 selects memory |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Request taken at this edge when req_valid is high |
| bus_ready | input | 1 | Device ready; low requests a wait state |
| ad_in | input | 8 | Byte read from the shared lines |
| ad_out | output | 8 | Byte driven onto the shared lines |
| ad_oe | output | 1 | Shared lines driven by the controller |
| addr_hi | output | 12 | Upper address bits, valid in T1 |
| addr_strobe | output | 1 | Address latch strobe (T1) |
| xmit | output | 1 | Direction: 1 transmit, 0 receive |
| io_sel | output | 1 | 1 I/O space, 0 memory space |
| rd_en | output | 1 | Read strobe |
| wr_en | output | 1 | Write strobe |
| data_en | output | 1 | Data transceiver enable |
| latched_addr | output | 20 | Demultiplexed address from the internal latch |
| rdata | output | 8 | Captured read byte |
| done | output | 1 | One-clock completion pulse in T4 |
| err | output | 1 | Wait ceiling reached; valid with done |

## Verification
The assertions take three things for granted about the inputs. `bus_ready` holds a defined level at every rising edge once reset is released. A request is offered only with stable fields, and those fields do not change until `req_ready` has taken it. The device model drives `bus_ready` and `ad_in` only on falling edges, from a per-transfer wait count that the driver queues. It keeps every field of a request constant until the acceptance edge. A wait count above the ceiling is used only on reads, so a timed-out write never reaches the model's storage.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_TW,
        ST_T3,
        ST_T4
    } bus_state_t;
endpackage

// File: rtl/mbc_wait_cnt.sv
module mbc_wait_cnt #(
    parameter int MAX_WAIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int CW = $clog2(MAX_WAIT + 1);
    localparam logic [CW-1:0] LIM = CW'(MAX_WAIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && (cnt_q != LIM)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign at_limit = (cnt_q == LIM);

    AST_WAIT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (at_limit && !clr) |=> at_limit); // R9
endmodule

// File: rtl/mbc_addr_latch.sv
module mbc_addr_latch #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [ADDR_W-1:0] bus_in,
    output logic [ADDR_W-1:0] addr_out
);
    logic [ADDR_W-1:0] hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (strobe) hold_d = bus_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign addr_out = hold_q;
endmodule

// File: rtl/mbc_fsm.sv
module mbc_fsm
    import mbc_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic                     req_io,
    input  logic                     req_write,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     req_ready,
    input  logic                     bus_ready,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic                     ale,
    output logic                     xmit,
    output logic                     io_sel,
    output logic                     rd_en,
    output logic                     wr_en,
    output logic                     data_en,
    output logic [DATA_W-1:0]        rdata,
    output logic                     done,
    output logic                     err,
    output logic                     wait_clr,
    output logic                     wait_inc,
    input  logic                     wait_at_limit
);
    typedef struct packed {
        bus_state_t        st;
        logic [ADDR_W-1:0] addr;
        logic              io;
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              err;
    } regs_t;

    regs_t cur_q, nxt_d;
    logic  strobe_phase;
    logic  can_take;

    assign can_take = (cur_q.st == ST_IDLE) || (cur_q.st == ST_T4);

    always_comb begin
        nxt_d    = cur_q;
        wait_clr = 1'b0;
        wait_inc = 1'b0;
        case (cur_q.st)
            ST_IDLE: ;
            ST_T1: begin
                wait_clr = 1'b1;
                nxt_d.st = ST_T2;
            end
            ST_T2: begin
                if (bus_ready) begin
                    nxt_d.st = ST_T3;
                end else begin
                    nxt_d.st = ST_TW;
                    wait_inc = 1'b1;
                end
            end
            ST_TW: begin
                if (bus_ready) begin
                    nxt_d.st = ST_T3;
                end else if (wait_at_limit) begin
                    nxt_d.st  = ST_T4;
                    nxt_d.err = 1'b1;
                end else begin
                    wait_inc = 1'b1;
                end
            end
            ST_T3: begin
                if (!cur_q.wr) nxt_d.rdata = ad_in;
                nxt_d.st = ST_T4;
            end
            ST_T4: nxt_d.st = ST_IDLE;
            default: nxt_d.st = ST_IDLE;
        endcase
        if (can_take && req_valid) begin
            nxt_d.st    = ST_T1;
            nxt_d.addr  = req_addr;
            nxt_d.io    = req_io;
            nxt_d.wr    = req_write;
            nxt_d.wdata = req_wdata;
            nxt_d.err   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q    <= '0;
            cur_q.st <= ST_IDLE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign strobe_phase = (cur_q.st == ST_T2) || (cur_q.st == ST_TW) ||
                          (cur_q.st == ST_T3);

    always_comb begin
        ale     = (cur_q.st == ST_T1);
        ad_oe   = ale || (cur_q.wr && (strobe_phase || cur_q.st == ST_T4));
        ad_out  = ale ? cur_q.addr[DATA_W-1:0] : cur_q.wdata;
        addr_hi = ale ? cur_q.addr[ADDR_W-1:DATA_W] : '0;
        xmit    = (cur_q.st != ST_IDLE) && cur_q.wr;
        io_sel  = (cur_q.st != ST_IDLE) && cur_q.io;
        rd_en   = strobe_phase && !cur_q.wr;
        wr_en   = strobe_phase && cur_q.wr;
        data_en = strobe_phase;
        done    = (cur_q.st == ST_T4);
        err     = done && cur_q.err;
    end

    assign req_ready = can_take;
    assign rdata     = cur_q.rdata;

    AST_WAIT_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_T2 && !bus_ready) |=> (cur_q.st == ST_TW)); // R4
    AST_READY_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_q.st == ST_T2 || cur_q.st == ST_TW) && bus_ready) |=> rd_en || wr_en); // R4
    AST_ABORT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_TW && !bus_ready && wait_at_limit) |=> (done && err)); // R9
    AST_DEN_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en || wr_en) |-> data_en); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_WR_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_en) |-> ad_oe); // R8
endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl #(
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 8,
    parameter int MAX_WAIT = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic                     req_io,
    input  logic                     req_write,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     req_ready,
    input  logic                     bus_ready,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic                     addr_strobe,
    output logic                     xmit,
    output logic                     io_sel,
    output logic                     rd_en,
    output logic                     wr_en,
    output logic                     data_en,
    output logic [ADDR_W-1:0]        latched_addr,
    output logic [DATA_W-1:0]        rdata,
    output logic                     done,
    output logic                     err
);
    logic wait_clr, wait_inc, wait_at_limit;

    mbc_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) fsm_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_io(req_io),
        .req_write(req_write), .req_wdata(req_wdata), .req_ready(req_ready),
        .bus_ready(bus_ready), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .addr_hi(addr_hi), .ale(addr_strobe), .xmit(xmit), .io_sel(io_sel),
        .rd_en(rd_en), .wr_en(wr_en), .data_en(data_en), .rdata(rdata),
        .done(done), .err(err), .wait_clr(wait_clr), .wait_inc(wait_inc),
        .wait_at_limit(wait_at_limit)
    );

    mbc_wait_cnt #(.MAX_WAIT(MAX_WAIT)) wait_i (
        .clk(clk), .rst_n(rst_n), .clr(wait_clr), .inc(wait_inc),
        .at_limit(wait_at_limit)
    );

    mbc_addr_latch #(.ADDR_W(ADDR_W)) latch_i (
        .clk(clk), .rst_n(rst_n), .strobe(addr_strobe),
        .bus_in({addr_hi, ad_out}), .addr_out(latched_addr)
    );

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        addr_strobe |=> !addr_strobe); // R2
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_strobe |=> $stable(latched_addr)); // R7
endmodule

// File: tb/mux_bus_ctrl_tb_top.sv
`timescale 1ns/1ps
module mux_bus_ctrl_tb_top;
    localparam int MAXW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [19:0] req_addr = '0;
    logic req_io = 1'b0, req_write = 1'b0;
    logic [7:0] req_wdata = '0;
    logic req_ready;
    logic bus_ready = 1'b1;
    logic [7:0] ad_in = '0;
    logic [7:0] ad_out;
    logic ad_oe;
    logic [11:0] addr_hi;
    logic addr_strobe, xmit, io_sel, rd_en, wr_en, data_en, done, err;
    logic [19:0] latched_addr;
    logic [7:0] rdata;

    always #10 clk = ~clk;

    mux_bus_ctrl #(.MAX_WAIT(MAXW)) dut_i (.*);

    typedef struct {
        logic [19:0] addr;
        bit io, wr, b2b, exp_err;
        logic [7:0] wdata, exp_rdata;
        int waits;
    } item_t;

    item_t sb_q[$];
    int dev_wait_q[$];
    int checks = 0, errors = 0, issued = 0, completed = 0;
    logic [7:0] dev_mem [2][256];
    logic [7:0] shadow [2][256];
    bit finished = 0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic issue(logic [19:0] a, bit io, bit wr, logic [7:0] wd, int waits, bit b2b);
        item_t it;
        @(negedge clk);
        it.addr = a; it.io = io; it.wr = wr; it.wdata = wd; it.waits = waits;
        it.b2b = b2b; it.exp_err = (waits > MAXW);
        it.exp_rdata = shadow[io][a[7:0]];
        if (wr && !it.exp_err) shadow[io][a[7:0]] = wd;
        sb_q.push_back(it);
        dev_wait_q.push_back(waits);
        issued++;
        req_addr = a; req_io = io; req_write = wr; req_wdata = wd; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic go_idle(int n);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // device model: drives ready and read data on falling edges
    int dcnt = 0, dwaits = 0;
    bit prev_wr = 0;
    always @(negedge clk) begin
        if (addr_strobe && dev_wait_q.size() > 0) dwaits = dev_wait_q.pop_front();
        if (prev_wr && !wr_en && ad_oe) dev_mem[io_sel][latched_addr[7:0]] = ad_out;
        prev_wr = wr_en;
        if (rd_en || wr_en) dcnt++;
        else dcnt = 0;
        bus_ready = (dcnt > dwaits);
        ad_in = (rd_en && dcnt > dwaits) ? dev_mem[io_sel][latched_addr[7:0]] : 8'hEE;
    end

    // monitor / scoreboard
    int ncyc = 0, last_done = -10, cyc = 0;
    bit active = 0;
    item_t cur;
    always @(negedge clk) begin
        ncyc++;
        if (rst_n && addr_strobe) begin
            if (sb_q.size() == 0) begin
                chk(0, "R10", "unexpected transfer", 1, 0);
            end else begin
                cur = sb_q.pop_front();
                active = 1; cyc = 1;
                chk(ad_oe && ad_out == cur.addr[7:0], "R2", "low address byte", ad_out, cur.addr[7:0]);
                chk(addr_hi == cur.addr[19:8], "R2", "upper address", addr_hi, cur.addr[19:8]);
                chk(xmit == cur.wr && io_sel == cur.io, "R2", "direction/space", {xmit, io_sel}, {cur.wr, cur.io});
                chk(!rd_en && !wr_en && !req_ready, "R10", "T1 quiet", {rd_en, wr_en, req_ready}, 0);
                if (cur.b2b) chk(ncyc == last_done + 1, "R10", "back-to-back start", ncyc, last_done + 1);
            end
        end else if (active) begin
            cyc++;
            chk(latched_addr == cur.addr, "R7", "latched address", latched_addr, cur.addr);
            chk(xmit == cur.wr && io_sel == cur.io, "R2", "held direction/space", {xmit, io_sel}, {cur.wr, cur.io});
            if (done) begin
                completed++;
                active = 0; last_done = ncyc;
                if (cur.exp_err)
                    chk(cyc == MAXW + 3, "R9", "abort length", cyc, MAXW + 3);
                else if (cur.waits == 0)
                    chk(cyc == 4, "R1", "no-wait length", cyc, 4);
                else
                    chk(cyc == 4 + cur.waits, "R4", "wait length", cyc, 4 + cur.waits);
                chk(err == cur.exp_err, "R9", "error flag", err, cur.exp_err);
                chk(!rd_en && !wr_en && !data_en && req_ready, "R6", "T4 strobes off", {rd_en, wr_en, data_en}, 0);
                if (cur.wr) chk(ad_oe && ad_out == cur.wdata, "R8", "data after write strobe", ad_out, cur.wdata);
                else if (!cur.exp_err) chk(rdata == cur.exp_rdata, "R5", "read data", rdata, cur.exp_rdata);
            end else begin
                chk(data_en && rd_en == !cur.wr && wr_en == cur.wr, "R3", "strobe phase", {data_en, rd_en, wr_en}, {1'b1, !cur.wr, cur.wr});
                if (cur.wr) chk(ad_oe && ad_out == cur.wdata, "R3", "write data driven", ad_out, cur.wdata);
                else chk(!ad_oe, "R3", "lines released on read", ad_oe, 0);
            end
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            dev_mem[0][i] = 8'(i) ^ 8'h5A; shadow[0][i] = 8'(i) ^ 8'h5A;
            dev_mem[1][i] = 8'(i) ^ 8'hC3; shadow[1][i] = 8'(i) ^ 8'hC3;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!addr_strobe && !rd_en && !wr_en && !data_en && !ad_oe && !done && !err && req_ready,
            "R11", "reset state", {addr_strobe, rd_en, wr_en, data_en, ad_oe, done, err, req_ready}, 1);
        issue(20'hA5F3C, 0, 0, 8'h00, 0, 0);           // R1 read, no wait
        issue(20'h1234A, 0, 1, 8'h9E, 0, 1);           // R10 back-to-back write
        issue(20'h1234A, 0, 0, 8'h00, 2, 1);           // R4 readback with waits
        go_idle(3);
        issue(20'h00042, 1, 1, 8'h71, 1, 0);           // I/O write, one wait
        issue(20'h00042, 1, 0, 8'h00, 0, 1);
        issue(20'hFFFFF, 0, 0, 8'h00, MAXW, 1);        // R4 waits at ceiling
        issue(20'h3C0D7, 0, 0, 8'h00, 255, 1);         // R9 abort
        issue(20'h3C0D7, 0, 1, 8'h3B, MAXW - 1, 1);
        go_idle(2);
        issue(20'h800D7, 0, 0, 8'h00, 0, 0);
        go_idle(20);
        chk(completed == issued, "R6", "completions", completed, issued);
        chk(dev_mem[0][8'h4A] == 8'h9E && dev_mem[1][8'h42] == 8'h71 && dev_mem[0][8'hD7] == 8'h3B,
            "R8", "device stored writes", {dev_mem[0][8'h4A], dev_mem[1][8'h42], dev_mem[0][8'hD7]}, 24'h9E713B);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule